// File: doc/BRIEF.md
# Ones-Density Guard for a T1 Bit Stream

This block watches a serial T1 bit stream, taking one bit on each cycle where the bit enable is high, and checks it against two ones-density rules. The first rule limits a run of zeros to at most 15 bits. The second rule covers 23 nested sliding windows: for each N from 1 to 23, every group of 8·(N+1) consecutive bits must hold at least N ones. The longest window is 192 bits. A sticky violation output reports any break of either rule until it is cleared.

When enforcement is turned on, the block looks at each incoming zero before sending it. If sending the zero would break either rule, the block sends a one in its place and increments a saturating count of forced bits. The monitor always judges the bit that is actually sent. A chip normally uses two copies of the block. One copy watches the receive path with enforcement off. The other copy sits on the transmit path and may enforce. Enforcement should stay off for line codes that already guarantee density.

After reset the bit history reads as all ones, so the partly filled history at start-up cannot cause a false violation.

Top module: `pulse_density_guard`

## Requirements
- R1: On a cycle with `bit_en` high, `dout` takes the emitted bit at the next clock edge. The emitted bit equals `din` whenever `din` is 1 or `enforce_en` is 0. `dout` holds its value on cycles with `bit_en` low.
- R2: An emitted zero that would be the 16th consecutive zero sets `viol` at the same edge that updates `dout`.
- R3: For each N from 1 to 23, an emitted bit that closes a window of 8·(N+1) bits holding fewer than N ones sets `viol`. Cycles with `bit_en` low never set `viol`.
- R4: After reset the history counts as all ones. Up to 15 zeros sent straight after reset raise no violation.
- R5: `viol` stays set until `clr_viol` is high on a clock edge. If a violating bit arrives on the same edge as the clear, `viol` stays set.
- R6: With `enforce_en` high, an incoming zero is replaced by a one exactly when sending the zero would break R2 or R3. A stream that is enforced from reset never sets `viol`.
- R7: `force_cnt` rises by one for each replaced bit and saturates at its all-ones value, which is 2^CNT_W − 1. An incoming one never changes it.
- R8: While `rst_n` is low, `dout`, `viol` and `force_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries a stream bit |
| din | input | 1 | Incoming stream bit |
| enforce_en | input | 1 | Turns on replacement of zeros that would break a rule |
| clr_viol | input | 1 | Clears the sticky violation flag |
| dout | output | 1 | Emitted stream bit, registered |
| viol | output | 1 | Sticky flag for a density rule violation |
| force_cnt | output | CNT_W | Saturating count of replaced bits |

## Verification
The checker assumes that `enforce_en` and `clr_viol` are sampled only at clock edges and that `din` has a defined value whenever `bit_en` is high. It also assumes that the flag decision made inside the block relates to the emitted bit of the same cycle. The stimulus changes every input only on falling clock edges. It holds `bit_en` continuously through long patterns and drops it only in marked idle stretches, where `din` is toggled on purpose. Each scenario starts from a fresh reset, so no property sees a history left over from an earlier pattern.

// File: rtl/pdm_pkg.sv
// Package: shared constants and helpers for the ones-density guard.
// Assumes windows grow in steps of BASE bits, with window N spanning BASE*(N+1) bits.
package pdm_pkg;

    // Length in bits of window number n, where n counts from 1.
    function automatic int win_len(input int n, input int base);
        return base * (n + 1);
    endfunction

    // Count width able to hold the value v.
    function automatic int cnt_bits(input int v);
        return $clog2(v + 1);
    endfunction

endpackage

// File: rtl/pdm_history.sv
// Module: shift register holding the most recently emitted bits.
// hist[0] is the newest bit. Reset loads all ones so a short history reads as compliant.
// Assumes shift_en is high for exactly one cycle per emitted bit.
module pdm_history #(
    parameter int HIST_LEN = 191
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                bit_in,
    output logic [HIST_LEN-1:0] hist
);

    logic [HIST_LEN-1:0] hist_q;

    // Shift the emitted bit in at the newest end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/pdm_window_bank.sv
// Module: bank of running ones-counters, one per nested window.
// Counter n holds the number of ones in the newest BASE*(n+1)-1 history bits, which
// excludes the bit about to be emitted. It reports whether a zero or a one emitted
// next would leave that window below its minimum of n ones.
// Assumes hist comes from pdm_history, which is preset to ones, so each counter
// resets to its full span.
module pdm_window_bank
    import pdm_pkg::*;
#(
    parameter int NUM_WIN  = 23,
    parameter int BASE     = 8,
    parameter int HIST_LEN = 191
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                bit_in,
    input  logic [HIST_LEN-1:0] hist,
    output logic                short_if_zero,
    output logic                short_if_one
);

    localparam int CW = cnt_bits(HIST_LEN);

    logic [NUM_WIN-1:0] zero_short;
    logic [NUM_WIN-1:0] one_short;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam int SPAN  = win_len(g + 1, BASE) - 1;
        localparam int NEED  = g + 1;
        logic [CW-1:0] ones_q;

        // Add the bit entering the span and drop the bit leaving it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ones_q <= CW'(SPAN);
            end else if (shift_en) begin
                ones_q <= ones_q + CW'(bit_in) - CW'(hist[SPAN-1]);
            end
        end

        // Compare the window's ones against its minimum for either choice of next bit.
        always_comb begin
            zero_short[g] = (ones_q < CW'(NEED));
            one_short[g]  = ({1'b0, ones_q} + 1'b1) < (CW + 1)'(NEED);
        end
    end

    assign short_if_zero = |zero_short;
    assign short_if_one  = |one_short;

endmodule

// File: rtl/pdm_zero_run.sv
// Module: counter for consecutive zeros at the newest end of the history.
// It saturates one step past the limit and reports when one more zero would be too many.
module pdm_zero_run #(
    parameter int MAX_ZEROS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic run_full
);

    localparam int RW = $clog2(MAX_ZEROS + 2);

    logic [RW-1:0] run_q;

    // Track the current zero run, restarting on every emitted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (shift_en) begin
            if (bit_in) begin
                run_q <= '0;
            end else if (run_q <= RW'(MAX_ZEROS)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign run_full = (run_q >= RW'(MAX_ZEROS));

endmodule

// File: rtl/pulse_density_guard.sv
// Module: ones-density monitor and optional enforcer for a serial T1 stream.
// Decides each bit before it is emitted: a zero that would break the run limit or a
// window minimum is replaced by a one when enforce_en is high. The monitor judges
// the emitted bit and sets a sticky flag. Output is registered.
// Assumes one bit per bit_en cycle; control inputs are synchronous to clk.
module pulse_density_guard
    import pdm_pkg::*;
#(
    parameter int NUM_WIN   = 23,
    parameter int BASE      = 8,
    parameter int MAX_ZEROS = 15,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             din,
    input  logic             enforce_en,
    input  logic             clr_viol,
    output logic             dout,
    output logic             viol,
    output logic [CNT_W-1:0] force_cnt
);

    localparam int HIST_LEN = win_len(NUM_WIN, BASE) - 1;

    logic [HIST_LEN-1:0] hist;
    logic                short_if_zero;
    logic                short_if_one;
    logic                run_full;
    logic                zero_breaks;
    logic                force_one;
    logic                emit_bit;
    logic                viol_now;
    logic                dout_q;
    logic                viol_q;
    logic [CNT_W-1:0]    fcnt_q;

    pdm_history #(.HIST_LEN(HIST_LEN)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_en),
        .bit_in   (emit_bit),
        .hist     (hist)
    );

    pdm_window_bank #(
        .NUM_WIN  (NUM_WIN),
        .BASE     (BASE),
        .HIST_LEN (HIST_LEN)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .shift_en      (bit_en),
        .bit_in        (emit_bit),
        .hist          (hist),
        .short_if_zero (short_if_zero),
        .short_if_one  (short_if_one)
    );

    pdm_zero_run #(.MAX_ZEROS(MAX_ZEROS)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_en),
        .bit_in   (emit_bit),
        .run_full (run_full)
    );

    // Choose the emitted bit and judge it against both rules.
    always_comb begin
        zero_breaks = run_full | short_if_zero;
        force_one   = enforce_en & ~din & zero_breaks;
        emit_bit    = din | force_one;
        viol_now    = emit_bit ? short_if_one : zero_breaks;
    end

    // Register the emitted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (bit_en) begin
            dout_q <= emit_bit;
        end
    end

    // Sticky violation flag; a new violation wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (bit_en && viol_now) begin
            viol_q <= 1'b1;
        end else if (clr_viol) begin
            viol_q <= 1'b0;
        end
    end

    // Saturating count of replaced zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (bit_en && force_one && (fcnt_q != '1)) begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    assign dout      = dout_q;
    assign viol      = viol_q;
    assign force_cnt = fcnt_q;

endmodule

// File: rtl/pdm_checker.sv
// Module: assertion checker for pulse_density_guard, attached by bind.
// Assumes a synchronous active-low reset that is asserted at time zero.
module pdm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             din,
    input logic             enforce_en,
    input logic             clr_viol,
    input logic             dout,
    input logic             viol,
    input logic [CNT_W-1:0] force_cnt,
    input logic             viol_now
);

    AST_ONES_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && din |=> dout); // R1
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !enforce_en |=> dout == $past(din)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dout)); // R1
    AST_FLAG_ON_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && viol_now |=> viol); // R2
    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !viol && !bit_en |=> !viol); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol && !clr_viol |=> viol); // R5
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_viol && !(bit_en && viol_now) |=> !viol); // R5
    AST_CNT_ONE_IN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && din |=> $stable(force_cnt)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cnt != $past(force_cnt)) |-> (force_cnt == $past(force_cnt) + 1'b1)); // R7
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(force_cnt)); // R7

endmodule

bind pulse_density_guard pdm_checker #(.CNT_W(CNT_W)) u_pdm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .din        (din),
    .enforce_en (enforce_en),
    .clr_viol   (clr_viol),
    .dout       (dout),
    .viol       (viol),
    .force_cnt  (force_cnt),
    .viol_now   (viol_now)
);

// File: tb/pulse_density_guard_test.sv
// Bench: a table of periodic patterns, then directed tests, all compared with a
// bit-level reference model built from the requirements.
module pulse_density_guard_test;

    localparam int CNT_W = 8;
    localparam int NWIN  = 23;
    localparam int HLEN  = 192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             din = 1'b0;
    logic             enforce_en = 1'b0;
    logic             clr_viol = 1'b0;
    logic             dout;
    logic             viol;
    logic [CNT_W-1:0] force_cnt;

    int chk_cnt = 0;
    int fail_cnt = 0;

    // Reference model state
    logic m_hist [HLEN];
    logic m_dout;
    logic m_viol;
    int   m_cnt;

    always #2.5 clk = ~clk;

    pulse_density_guard #(.CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .din        (din),
        .enforce_en (enforce_en),
        .clr_viol   (clr_viol),
        .dout       (dout),
        .viol       (viol),
        .force_cnt  (force_cnt)
    );

    // Fields: period[21:14] (0 = all zeros), length[13:2], enforce[1], expected flag[0]
    localparam logic [21:0] VEC [8] = '{
        {8'd1,  12'd300, 1'b0, 1'b0},
        {8'd8,  12'd400, 1'b0, 1'b0},
        {8'd9,  12'd400, 1'b0, 1'b1},
        {8'd16, 12'd100, 1'b0, 1'b1},
        {8'd17, 12'd100, 1'b1, 1'b0},
        {8'd0,  12'd500, 1'b1, 1'b0},
        {8'd12, 12'd400, 1'b1, 1'b0},
        {8'd9,  12'd400, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    endtask

    task automatic model_reset();
        for (int i = 0; i < HLEN; i++) m_hist[i] = 1'b1;
        m_dout = 1'b0;
        m_viol = 1'b0;
        m_cnt  = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        clr_viol = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    // One stream bit: the model decides from the rules, then the outputs are compared.
    task automatic send(input logic b, input logic clr);
        bit zbad, obad, frc, e, vn;
        int zr, s, wl;
        @(negedge clk);
        din = b;
        bit_en = 1'b1;
        clr_viol = clr;
        zr = 0;
        while (zr < HLEN && m_hist[zr] == 1'b0) zr++;
        zbad = (zr >= 15);
        obad = 1'b0;
        for (int n = 1; n <= NWIN; n++) begin
            wl = 8 * (n + 1);
            s = 0;
            for (int k = 0; k < wl - 1; k++) s += int'(m_hist[k]);
            if (s < n) zbad = 1'b1;
            if (s + 1 < n) obad = 1'b1;
        end
        frc = enforce_en && !b && zbad;
        e = b || frc;
        vn = e ? obad : zbad;
        for (int k = HLEN - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = e;
        m_dout = e;
        if (vn) m_viol = 1'b1;
        else if (clr) m_viol = 1'b0;
        if (frc && m_cnt < (1 << CNT_W) - 1) m_cnt++;
        @(posedge clk);
        #1;
        check(dout == m_dout, enforce_en ? "R6 emitted bit" : "R1 emitted bit", dout, m_dout);
        check(viol == m_viol, "R3 flag", viol, m_viol);
        check(int'(force_cnt) == m_cnt, "R7 count", force_cnt, m_cnt);
    endtask

    task automatic idle(input int cycles);
        logic d0, v0;
        for (int i = 0; i < cycles; i++) begin
            d0 = dout;
            v0 = viol;
            @(negedge clk);
            bit_en = 1'b0;
            clr_viol = 1'b0;
            din = ~din;
            @(posedge clk);
            #1;
            check(dout == d0, "R1 hold while idle", dout, d0);
            check(viol == v0, "R3 no flag while idle", viol, v0);
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        fail_cnt++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int per, len;
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        // R8: reset state
        check(dout == 1'b0, "R8 dout in reset", dout, 0);
        check(viol == 1'b0, "R8 flag in reset", viol, 0);
        check(force_cnt == '0, "R8 count in reset", force_cnt, 0);

        // Table of periodic patterns
        for (int i = 0; i < 8; i++) begin
            per = int'(VEC[i][21:14]);
            len = int'(VEC[i][13:2]);
            do_reset();
            enforce_en = VEC[i][1];
            for (int j = 0; j < len; j++) begin
                send((per != 0) && (j % per == 0), 1'b0);
            end
            check(viol == VEC[i][0], VEC[i][1] ? "R6 enforced pattern flag" : "R3 pattern flag",
                  viol, VEC[i][0]);
            if (VEC[i][1] && per == 0)
                check(force_cnt != '0, "R6 zeros replaced", force_cnt, 1);
        end

        // R4 and R2: run of zeros after reset
        do_reset();
        enforce_en = 1'b0;
        for (int j = 0; j < 15; j++) send(1'b0, 1'b0);
        check(viol == 1'b0, "R4 fifteen zeros after reset", viol, 0);
        send(1'b0, 1'b0);
        check(viol == 1'b1, "R2 sixteenth zero", viol, 1);
        idle(4);
        check(viol == 1'b1, "R5 flag holds", viol, 1);
        // R5: clear on a compliant bit
        send(1'b1, 1'b1);
        check(viol == 1'b0, "R5 clear", viol, 0);
        check(dout == 1'b1, "R1 one passes", dout, 1);
        // R5: violating bit wins over a clear
        for (int j = 0; j < 15; j++) send(1'b0, 1'b0);
        send(1'b0, 1'b1);
        check(viol == 1'b1, "R5 set wins over clear", viol, 1);

        // R6: enforcement on a long zero run replaces exactly the 16th zero
        do_reset();
        enforce_en = 1'b1;
        for (int j = 0; j < 15; j++) send(1'b0, 1'b0);
        check(force_cnt == '0, "R6 no early replacement", force_cnt, 0);
        send(1'b0, 1'b0);
        check(dout == 1'b1, "R6 sixteenth zero replaced", dout, 1);
        check(viol == 1'b0, "R6 no flag when enforced", viol, 0);
        idle(3);

        // R7: saturation of the replaced-bit count
        for (int j = 0; j < 2500; j++) send(1'b0, 1'b0);
        check(int'(force_cnt) == (1 << CNT_W) - 1, "R7 saturation", force_cnt, (1 << CNT_W) - 1);
        send(1'b1, 1'b0);
        check(int'(force_cnt) == (1 << CNT_W) - 1, "R7 one leaves count", force_cnt,
              (1 << CNT_W) - 1);
        check(viol == 1'b0, "R6 long enforced run clean", viol, 0);

        // R8: reset in the middle of a stream
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        @(posedge clk);
        #1;
        check(dout == 1'b0 && viol == 1'b0 && force_cnt == '0, "R8 mid-stream reset",
              {dout, viol, force_cnt}, 0);
        finish_run();
    end

endmodule